// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the protocol side of a two-wire bus slave fronting a 64K-by-8 memory. It runs on a fast system clock and oversamples the bus clock and data lines. SDA is driven only through an open-drain pull-low enable. The engine spots bus START and STOP conditions and checks the select byte against a fixed device code and two strap pins. It takes a 16-bit memory address in two bytes and serves reads from a synchronous memory port that has one cycle of latency. It also keeps the internal address pointer.

Write data never touches storage here. Each accepted byte comes out as a single-cycle strobe carrying its address. A separate page-latch block collects these strobes and is told to commit by a pulse on STOP.

The pointer advances in one of two ways. After a read it counts through the whole 16-bit space. After a write it wraps inside the 128-byte page, so the upper nine address bits are held. A random read is a write header that carries only the address, followed by a repeated START with a read-mode select byte.

Top module: `smem_slave`

## Requirements
- R1: A START (SDA falling while SCL is high) or a STOP (SDA rising while SCL is high) cancels whatever transfer is in progress, including a partly received address byte. The pointer keeps the value it had before the cancelled transfer.
- R2: The select byte is bits 7:4 = 1010, bit 3 ignored, bits 2:1 compared with `strap_addr`, and bit 0 the direction (1 = read). On a mismatch the engine gives no acknowledge, never drives SDA and ignores bytes until the next START.
- R3: Every byte the engine accepts is acknowledged by holding SDA low for the whole of the ninth SCL clock.
- R4: Bytes are sent most significant bit first. Received bits are sampled on SCL rising and driven bits are changed after SCL falling, so the engine changes `sda_oe` only while SCL is low.
- R5: A write header is followed by the address high byte and then the low byte. Each data byte then produces exactly one `wr_valid` pulse carrying the pointer address and the byte. `wr_valid` and `mem_rd_en` are never high together.
- R6: After each write byte the pointer advances within its 128-byte page. Bits 15:7 are held and 0x7F wraps to 0x00.
- R7: A STOP after at least one written data byte gives one `wr_commit` pulse. A STOP after a header that carries only the address gives none.
- R8: A read with no address phase returns the byte at the pointer. Each byte read advances the pointer across the full array, so 0xFFFF is followed by 0x0000. After reset the pointer is 0.
- R9: Address bytes, then a repeated START, then a read-mode select byte returns the byte at the loaded address.
- R10: While the master ACKs (SDA low in the ninth clock), bytes at successive addresses are sent. After a NACK the engine releases SDA and drives nothing more until a new START.
- R11: During reset and right after it the engine is idle, with `sda_oe`, `mem_rd_en`, `wr_valid` and `wr_commit` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Bus clock line level, asynchronous |
| sda_in | input | 1 | Bus data line level as seen on the wire, asynchronous |
| strap_addr | input | 2 | Strap pins compared with select bits 2:1 |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| mem_rd_en | output | 1 | Read strobe to the memory |
| mem_rd_addr | output | 16 | Read address |
| mem_rd_data | input | 8 | Read data, valid one cycle after `mem_rd_en` |
| wr_valid | output | 1 | One-cycle strobe per accepted write byte |
| wr_addr | output | 16 | Address for the write byte |
| wr_data | output | 8 | Write byte |
| wr_commit | output | 1 | One-cycle pulse on STOP after written data |

## Verification
Two pairs of events can fall in the same cycle. First, a write-byte strobe and a pointer advance coincide at a page boundary. A four-byte page write starting two bytes below the boundary provokes this, and the bench checks that the third strobe carries the wrapped in-page address and that a following pointer read returns the next byte of the same page. Second, a master ACK and a memory fetch with a pointer step coincide. A sequential read starting at 0xFFFE crosses the top of the array, and the bench checks the bytes at 0xFFFF and 0x0000. On every clock the bench also compares write strobes against a queue of expected address and data pairs, and it flags any move of `sda_oe` while its own SCL is high.

// File: rtl/smem_pkg.sv
// Shared types and constants for the serial memory slave engine.
// Assumes an 8-bit byte-oriented bus protocol with a ninth acknowledge clock.
package smem_pkg;
    localparam logic [3:0] DEV_CODE = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_AHI,
        ST_ALO,
        ST_WDAT,
        ST_RDAT
    } smem_state_t;
endpackage

// File: rtl/smem_line_sync.sv
// Synchronizes the bus clock and data lines into the system clock domain and
// flags SCL edges plus START/STOP conditions on the synchronized values.
// Assumes SCL/SDA are held for several system clocks per level.
module smem_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic cond_start,
    output logic cond_stop
);
    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_q;
    logic              sda_q;

    // Metastability chains plus one delay stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[STAGES-2:0], scl_in};
            sda_ff <= {sda_ff[STAGES-2:0], sda_in};
            scl_q  <= scl_ff[STAGES-1];
            sda_q  <= sda_ff[STAGES-1];
        end
    end

    // Edge and condition decode on the synchronized samples.
    always_comb begin
        scl_lvl    = scl_ff[STAGES-1];
        sda_lvl    = sda_ff[STAGES-1];
        scl_rise   = scl_lvl & ~scl_q;
        scl_fall   = ~scl_lvl & scl_q;
        cond_start = scl_lvl & scl_q & sda_q & ~sda_lvl;
        cond_stop  = scl_lvl & scl_q & ~sda_q & sda_lvl;
    end
endmodule

// File: rtl/smem_addr_ctr.sv
// Internal address pointer. Loads a new address, or steps by one either
// across the full space or inside the current page only.
// Assumes load has priority and the two step requests are never both high.
module smem_addr_ctr #(
    parameter int AW = 16,
    parameter int PW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step_full,
    input  logic          step_page,
    output logic [AW-1:0] addr
);
    logic [PW-1:0] pg_nxt;

    // Next in-page offset with wrap at the page end.
    always_comb pg_nxt = addr[PW-1:0] + PW'(1);

    // Pointer register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (load) begin
            addr <= load_val;
        end else if (step_full) begin
            addr <= addr + AW'(1);
        end else if (step_page) begin
            addr <= {addr[AW-1:PW], pg_nxt};
        end
    end

    // R6: a page step keeps the page and adds one to the offset.
    a_r6_page_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (step_page && !load && !step_full) |=>
            (addr[AW-1:PW] == $past(addr[AW-1:PW]) &&
             addr[PW-1:0] == PW'($past(addr[PW-1:0]) + PW'(1))));

    // R8: a full step from the top wraps to zero.
    a_r8_full_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (step_full && !load && addr == '1) |=> (addr == '0));
endmodule

// File: rtl/smem_slave.sv
// Two-wire bus slave protocol engine for a 64K x 8 memory.
// Assumes a synchronous read port with one cycle latency and an external
// page-latch block consuming wr_valid/wr_commit. SDA is driven open-drain.
module smem_slave
    import smem_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int PAGE_W = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic [1:0]        strap_addr,
    output logic              sda_oe,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [7:0]        mem_rd_data,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              wr_commit
);
    localparam int CW = $clog2(9 + 1);
    localparam logic [CW-1:0] BITS_DONE = CW'(8);

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, cond_start, cond_stop;
    smem_state_t st;
    logic [CW-1:0] bcnt;
    logic          ackph;
    logic [7:0]    sh, tx, ahi;
    logic          rd_pend, wr_any;
    logic          rx_state, rx_done, dev_ok, rd_fetch, ctr_load;
    logic [2:0]    tx_sel;
    logic [ADDR_W-1:0] ptr;

    smem_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .cond_start(cond_start), .cond_stop(cond_stop)
    );

    smem_addr_ctr #(.AW(ADDR_W), .PW(PAGE_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .load(ctr_load),
        .load_val(ADDR_W'({ahi, sh})), .step_full(rd_fetch),
        .step_page(wr_valid), .addr(ptr)
    );

    // Decode of byte completion, select match and port strobes.
    always_comb begin
        rx_state    = (st == ST_DEV) || (st == ST_AHI) || (st == ST_ALO) || (st == ST_WDAT);
        rx_done     = rx_state && scl_fall && !ackph && (bcnt == BITS_DONE);
        dev_ok      = (sh[7:4] == DEV_CODE) && (sh[2:1] == strap_addr);
        ctr_load    = rx_done && (st == ST_ALO);
        wr_valid    = rx_done && (st == ST_WDAT);
        rd_fetch    = (rx_done && (st == ST_DEV) && dev_ok && sh[0]) ||
                      ((st == ST_RDAT) && ackph && scl_rise && !sda_lvl);
        mem_rd_en   = rd_fetch;
        mem_rd_addr = ptr;
        wr_addr     = ptr;
        wr_data     = sh;
        tx_sel      = 3'(CW'(7) - bcnt);
    end

    // Read data capture one cycle after the fetch strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_pend <= 1'b0;
            tx      <= '0;
        end else begin
            rd_pend <= rd_fetch;
            if (rd_pend) tx <= mem_rd_data;
        end
    end

    // Protocol state machine: bit counting, acknowledge and data drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            bcnt      <= '0;
            ackph     <= 1'b0;
            sda_oe    <= 1'b0;
            sh        <= '0;
            ahi       <= '0;
            wr_any    <= 1'b0;
            wr_commit <= 1'b0;
        end else begin
            wr_commit <= 1'b0;
            if (cond_start) begin
                st     <= ST_DEV;
                bcnt   <= '0;
                ackph  <= 1'b0;
                sda_oe <= 1'b0;
                wr_any <= 1'b0;
            end else if (cond_stop) begin
                st        <= ST_IDLE;
                bcnt      <= '0;
                ackph     <= 1'b0;
                sda_oe    <= 1'b0;
                wr_commit <= wr_any;
                wr_any    <= 1'b0;
            end else if (rx_state) begin
                if (scl_rise && !ackph && bcnt < BITS_DONE) begin
                    sh   <= {sh[6:0], sda_lvl};
                    bcnt <= bcnt + CW'(1);
                end
                if (rx_done) begin
                    if (st == ST_DEV && !dev_ok) begin
                        st   <= ST_IDLE;
                        bcnt <= '0;
                    end else begin
                        ackph  <= 1'b1;
                        sda_oe <= 1'b1;
                        if (st == ST_WDAT) wr_any <= 1'b1;
                        if (st == ST_AHI) ahi <= sh;
                    end
                end
                if (scl_fall && ackph) begin
                    ackph  <= 1'b0;
                    bcnt   <= '0;
                    sda_oe <= 1'b0;
                    case (st)
                        ST_DEV: begin
                            if (sh[0]) begin
                                st     <= ST_RDAT;
                                sda_oe <= ~tx[7];
                            end else begin
                                st <= ST_AHI;
                            end
                        end
                        ST_AHI:  st <= ST_ALO;
                        default: st <= ST_WDAT;
                    endcase
                end
            end else if (st == ST_RDAT) begin
                if (scl_rise && !ackph && bcnt < BITS_DONE) bcnt <= bcnt + CW'(1);
                if (scl_fall && !ackph) begin
                    if (bcnt == BITS_DONE) begin
                        sda_oe <= 1'b0;
                        ackph  <= 1'b1;
                    end else begin
                        sda_oe <= ~tx[tx_sel];
                    end
                end
                if (scl_rise && ackph && sda_lvl) begin
                    st    <= ST_IDLE;
                    ackph <= 1'b0;
                    bcnt  <= '0;
                end
                if (scl_fall && ackph) begin
                    ackph  <= 1'b0;
                    bcnt   <= '0;
                    sda_oe <= ~tx[7];
                end
            end
        end
    end

    // R4: the pull-down only moves while the synchronized SCL is low.
    a_r4_oe_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_lvl);

    // R2: an idle engine never drives the line.
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> !sda_oe);

    // R5: write strobe and read fetch are exclusive.
    a_r5_port_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd_en, wr_valid}));

    // R10: a master NACK leaves the engine idle and released.
    a_r10_nack_release: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RDAT && ackph && scl_rise && sda_lvl && !cond_start && !cond_stop)
            |=> (st == ST_IDLE && !sda_oe));

    // R7: a commit pulse only follows a stop condition.
    a_r7_commit_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_commit) |-> $past(cond_stop));
endmodule

// File: tb/smem_slave_tb.sv
// Bench for smem_slave: bus master tasks, a behavioural memory and pointer
// model, and a per-clock monitor of write strobes and SDA drive timing.
module smem_slave_tb;
    localparam int Q = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_scl = 1'b1;
    logic        m_sda = 1'b1;
    logic [1:0]  strap = 2'b10;
    logic        sda_oe, mem_rd_en, wr_valid, wr_commit;
    logic [15:0] mem_rd_addr, wr_addr;
    logic [7:0]  mem_rd_data = 8'h00;
    logic [7:0]  wr_data;
    wire         sda_line = m_sda & ~sda_oe;

    int checks = 0;
    int fails = 0;
    int commits = 0;
    bit done = 0;
    logic [23:0] exp_wr [$];
    logic [7:0]  wmem [bit [15:0]];
    logic        prev_oe = 1'b0;

    always #2 clk = ~clk;

    smem_slave u_dut (
        .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line),
        .strap_addr(strap), .sda_oe(sda_oe), .mem_rd_en(mem_rd_en),
        .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_commit(wr_commit)
    );

    function automatic logic [7:0] rdm(input logic [15:0] a);
        if (wmem.exists(a)) return wmem[a];
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Memory model: synchronous read, writes land when strobed.
    always @(posedge clk) begin
        if (mem_rd_en) mem_rd_data <= rdm(mem_rd_addr);
        if (wr_valid) wmem[wr_addr] = wr_data;
    end

    // Per-clock monitor away from the edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_valid) begin
                if (exp_wr.size() == 0) begin
                    chk(0, "R5 unexpected write strobe", {wr_addr, wr_data}, 0);
                end else begin
                    logic [23:0] e;
                    e = exp_wr.pop_front();
                    chk({wr_addr, wr_data} == e, "R5/R6 write strobe", {wr_addr, wr_data}, e);
                end
            end
            if (wr_commit) commits++;
            if (sda_oe != prev_oe) chk(!m_scl, "R4 sda_oe moved with SCL high", m_scl, 0);
        end
        prev_oe <= sda_oe;
    end

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic xfer(input bit b, output bit s);
        m_sda = b; wq();
        m_scl = 1'b1; wq();
        s = sda_line; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic bstart();
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b0; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic bstop();
        m_sda = 1'b0; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b1; wq(); wq();
    endtask

    task automatic wbyte(input logic [7:0] v, output bit acked);
        bit s;
        for (int i = 7; i >= 0; i--) xfer(v[i], s);
        xfer(1'b1, s);
        acked = !s;
    endtask

    task automatic rbyte(input bit nack, output logic [7:0] v);
        bit s;
        v = '0;
        for (int i = 0; i < 8; i++) begin
            xfer(1'b1, s);
            v = {v[6:0], s};
        end
        xfer(nack, s);
    endtask

    task automatic whdr(input logic [7:0] v, input string tag);
        bit a;
        wbyte(v, a);
        chk(a, tag, a, 1);
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=hang expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        bit a;
        bit s;
        logic [15:0] p;
        repeat (5) @(negedge clk);
        chk(!sda_oe && !mem_rd_en && !wr_valid && !wr_commit, "R11 reset outputs",
            {sda_oe, mem_rd_en, wr_valid, wr_commit}, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(!sda_oe, "R11 idle after reset", sda_oe, 0);

        // R11/R8: pointer read after reset returns address 0.
        bstart(); whdr(8'hA5, "R3 ack read select");
        rbyte(1'b1, d); chk(d == rdm(16'h0000), "R11 pointer zero read", d, rdm(16'h0000));
        bstop(); p = 16'h0001;

        // R2: strap mismatch and wrong device code get no ack.
        bstart(); wbyte(8'hA0, a); chk(!a, "R2 strap mismatch nack", a, 0);
        wbyte(8'h00, a); chk(!a, "R2 silent after mismatch", a, 0);
        bstop();
        bstart(); wbyte(8'hB4, a); chk(!a, "R2 wrong code nack", a, 0);
        bstop();

        // R5/R6/R7: page write crossing the page end, bit 3 set (ignored).
        bstart(); whdr(8'hAC, "R2 bit3 ignored ack");
        whdr(8'h12, "R3 ack addr hi"); whdr(8'hFE, "R3 ack addr lo");
        exp_wr.push_back({16'h12FE, 8'h11}); exp_wr.push_back({16'h12FF, 8'h22});
        exp_wr.push_back({16'h1280, 8'h33}); exp_wr.push_back({16'h1281, 8'h44});
        whdr(8'h11, "R3 ack data"); whdr(8'h22, "R3 ack data");
        whdr(8'h33, "R6 ack data at wrap"); whdr(8'h44, "R3 ack data");
        bstop();
        chk(commits == 1, "R7 commit after data", commits, 1);
        chk(exp_wr.size() == 0, "R5 all strobes seen", exp_wr.size(), 0);
        p = 16'h1282;

        // R8: pointer read after write.
        bstart(); whdr(8'hA5, "R3 ack");
        rbyte(1'b1, d); chk(d == rdm(p), "R8 pointer after write", d, rdm(p));
        bstop(); p = p + 16'h1;

        // R6: single write at page end wraps the pointer into the page.
        bstart(); whdr(8'hA4, "R3 ack"); whdr(8'h12, "R3 ack"); whdr(8'h7F, "R3 ack");
        exp_wr.push_back({16'h127F, 8'h5C}); whdr(8'h5C, "R3 ack");
        bstop();
        chk(commits == 2, "R7 second commit", commits, 2);
        bstart(); whdr(8'hA5, "R3 ack");
        rbyte(1'b1, d); chk(d == rdm(16'h1200), "R6 pointer wraps in page", d, rdm(16'h1200));
        bstop();

        // R7: address-only header then STOP gives no commit.
        bstart(); whdr(8'hA4, "R3 ack"); whdr(8'h30, "R3 ack"); whdr(8'h00, "R3 ack");
        bstop();
        chk(commits == 2, "R7 no commit without data", commits, 2);

        // R9/R10: random then sequential read across the page end.
        bstart(); whdr(8'hA4, "R3 ack"); whdr(8'h12, "R3 ack"); whdr(8'hFE, "R3 ack");
        bstart(); whdr(8'hA5, "R9 ack after repeated start");
        rbyte(1'b0, d); chk(d == 8'h11, "R9 random read data", d, 8'h11);
        rbyte(1'b0, d); chk(d == 8'h22, "R10 sequential read", d, 8'h22);
        rbyte(1'b0, d); chk(d == rdm(16'h1300), "R10 sequential full step", d, rdm(16'h1300));
        rbyte(1'b1, d); chk(d == rdm(16'h1301), "R10 last byte", d, rdm(16'h1301));
        bstop();

        // R8/R10: rollover at the top of the array.
        bstart(); whdr(8'hA4, "R3 ack"); whdr(8'hFF, "R3 ack"); whdr(8'hFE, "R3 ack");
        bstart(); whdr(8'hA5, "R3 ack");
        rbyte(1'b0, d); chk(d == rdm(16'hFFFE), "R8 read FFFE", d, rdm(16'hFFFE));
        rbyte(1'b0, d); chk(d == rdm(16'hFFFF), "R8 read FFFF", d, rdm(16'hFFFF));
        rbyte(1'b1, d); chk(d == rdm(16'h0000), "R8 rollover to 0", d, rdm(16'h0000));
        bstop();
        bstart(); whdr(8'hA5, "R3 ack");
        rbyte(1'b1, d); chk(d == rdm(16'h0001), "R8 pointer after rollover", d, rdm(16'h0001));
        bstop();

        // R10: after NACK with no STOP the line stays released.
        bstart(); whdr(8'hA4, "R3 ack"); whdr(8'h00, "R3 ack"); whdr(8'h40, "R3 ack");
        bstart(); whdr(8'hA5, "R3 ack");
        rbyte(1'b1, d); chk(d == rdm(16'h0040), "R9 read 0040", d, rdm(16'h0040));
        rbyte(1'b1, d); chk(d == 8'hFF, "R10 released after nack", d, 8'hFF);

        // R1: START in the middle of an address byte aborts it.
        bstart(); whdr(8'hA4, "R3 ack"); whdr(8'h77, "R3 ack");
        for (int i = 0; i < 4; i++) xfer(1'b0, s);
        bstart(); whdr(8'hA5, "R1 select after abort");
        rbyte(1'b1, d); chk(d == rdm(16'h0041), "R1 pointer kept after abort", d, rdm(16'h0041));
        bstop();
        chk(exp_wr.size() == 0 && commits == 2, "R5 no stray strobes", exp_wr.size(), 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule